// File: doc/BRIEF.md
# Serial Slave Response Decoder

This block listens to the slave's side of a two-wire serial management link after the master has sent a request. It is armed by a one-cycle `req_go` pulse that carries the request's context: the addressed slave ID, whether the request was an interrupt poll, whether it was a read, and the read size. The block then sits out a fixed turnaround and hunts for the slave's start bit, giving up after a bounded number of bit periods. Once the start bit is seen, it decodes the whole reply: the slave ID, the variable-length response code, any read data or interrupt-poll fields, and the 4-bit check code. A closing turnaround hands the wire back to the master, and the block ends with a one-cycle done pulse.

All line bits are sampled on `fall_stb`, a one-cycle strobe that marks a falling edge of the serial clock, synchronous to `clk`. `din` is the already de-inverted logical data value. The control is a single state machine: `S_IDLE`, `S_TAR_IN` (request turnaround), `S_WAIT` (start-bit search), `S_ID`, `S_CODE`, `S_RDATA`, `S_IRQF` (interrupt field), `S_DMAF` (DMA control field), `S_CRC` and `S_TAR_OUT` (closing turnaround). The transitions are: `S_IDLE`→`S_TAR_IN` on `req_go`; `S_TAR_IN`→`S_WAIT` after 3 strobes; `S_WAIT`→`S_ID` on a 1, or →`S_IDLE` with a timeout after 256 zeros; `S_ID`→`S_CODE` after 2 bits; `S_CODE`→`S_IRQF` on the short interrupt-poll code, →`S_RDATA` on a read acknowledge, else →`S_CRC`; `S_RDATA`→`S_CRC`; `S_IRQF`→`S_DMAF`→`S_CRC`; `S_CRC`→`S_TAR_OUT` after 4 bits; `S_TAR_OUT`→`S_IDLE` after 3 strobes, with the done pulse.

Top module: `slv_resp_dec`

## Requirements
- R1: After reset `rsp_valid` and `rsp_timeout` are 0, `rsp_kind` is 7 (none), and `rsp_data`, `rsp_irq`, `rsp_dma`, `rsp_crc_ok`, `rsp_id_mismatch` and `busy_cnt` are 0.
- R2: The block only acts after a `req_go` pulse in idle. The first 3 `fall_stb` samples after it are a turnaround: their values are ignored, and the check accumulator is held at zero.
- R3: After the turnaround, the first sample equal to 1 within 256 samples is the start bit. If 256 consecutive samples are 0, `rsp_timeout` pulses for one cycle, `rsp_kind` becomes 7, no done pulse follows, and the block returns to idle.
- R4: The 2-bit response slave ID is sent with its first bit as the LSB. `rsp_id_mismatch` is 1 when it differs from `req_id`.
- R5: The response code is two bits, MSB first, and `rsp_kind` encodes it as follows: 00 gives 0 (acknowledge), or 4 (acknowledge with data) when `req_read` is 1; 01 gives 1 (busy); 10 gives 2 (error, low class); 11 gives 3 (error, high class).
- R6: When `req_ipoll` is 1 and the response ID matches `req_id`, a first code bit of 0 alone gives `rsp_kind` 5. It is followed by a 2-bit interrupt field (`rsp_irq`) and then a 3-bit DMA control field (`rsp_dma`), each MSB first. A first bit of 1, or a mismatching ID, uses the 2-bit code of R5.
- R7: An acknowledge with data is followed by read data, MSB first. Its length is set by `req_size`: 8 bits for 00, 16 for 01, 32 otherwise. The data appears right-justified on `rsp_data`, and `rsp_data` is 0 for every other response.
- R8: The check code is a 4-bit Galois LFSR with polynomial x^4+x^2+x+1 (feedback taps 0x7), starting from zero. It runs over the start bit and every following bit up to the 4 check bits, which are sent MSB first. `rsp_crc_ok` is 1 when they equal the accumulated value.
- R9: After the check bits, 3 more samples are ignored as turnaround. `rsp_valid` then pulses for exactly one cycle, while all response outputs are valid.
- R10: `busy_cnt` increments, saturating, on each busy response from the addressed slave. It clears on any other response from that slave, and is unchanged by mismatched-ID responses and timeouts.
- R11: `din` is taken only in cycles with `fall_stb` high, and its value in other cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fall_stb | input | 1 | One-cycle strobe marking a serial clock falling edge |
| din | input | 1 | Logical line data |
| req_go | input | 1 | Request finished; start turnaround and latch context |
| req_id | input | 2 | Slave ID of the request |
| req_ipoll | input | 1 | Request was an interrupt poll |
| req_read | input | 1 | Request was a read |
| req_size | input | 2 | Read size: 00 byte, 01 half word, else word |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_kind | output | 3 | Response kind code (R5, R6; 7 none) |
| rsp_data | output | 32 | Read data, right-justified |
| rsp_irq | output | 2 | Interrupt field of a poll response |
| rsp_dma | output | 3 | DMA control field of a poll response |
| rsp_crc_ok | output | 1 | Check code matched |
| rsp_id_mismatch | output | 1 | Response ID differs from request ID |
| rsp_timeout | output | 1 | One-cycle pulse: no start bit in time |
| busy_cnt | output | 8 | Consecutive busy responses from the addressed slave |

## Verification
The bench goes after the edges of the start-bit window. A start bit on the 256th sample must be accepted, and 256 zeros must time out. An off-by-one counter would reject the first case or accept a late start. Ones driven during both turnarounds, and opposite values between strobes, expose a decoder that reads the wrong samples: it would start early or misread every field. The short interrupt-poll code is tried with a matching and a mismatching ID and with a leading 1. A design that ignored context would then misframe all later bits and fail the check code. Busy runs broken by a foreign-ID reply and by an error reply show whether the counter resets or holds as it should.

// File: rtl/slv_resp_dec_pkg.sv
package slv_resp_dec_pkg;

    localparam int RD_W = 32;

    typedef enum logic [2:0] {
        RSP_ACK      = 3'd0,
        RSP_BUSY     = 3'd1,
        RSP_ERR_LO   = 3'd2,
        RSP_ERR_HI   = 3'd3,
        RSP_ACK_DATA = 3'd4,
        RSP_IRQPOLL  = 3'd5,
        RSP_NONE     = 3'd7
    } rsp_kind_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_TAR_IN,
        S_WAIT,
        S_ID,
        S_CODE,
        S_RDATA,
        S_IRQF,
        S_DMAF,
        S_CRC,
        S_TAR_OUT
    } dec_state_e;

endpackage

// File: rtl/rsp_bitcnt.sv
module rsp_bitcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/rsp_crc4.sv
module rsp_crc4 #(
    parameter int         W    = 4,
    parameter logic [W-1:0] POLY = 4'h7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_i,
    output logic [W-1:0] crc_q,
    output logic [W-1:0] crc_nx
);
    logic fb;
    assign fb = crc_q[W-1] ^ bit_i;

    for (genvar i = 0; i < W; i++) begin : g_tap
        if (i == 0) begin : g_lsb
            assign crc_nx[i] = fb;
        end else begin : g_up
            assign crc_nx[i] = crc_q[i-1] ^ (POLY[i] & fb);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc_q <= '0;
        end else if (en) begin
            crc_q <= crc_nx;
        end
    end
endmodule

// File: rtl/slv_resp_dec.sv
module slv_resp_dec
    import slv_resp_dec_pkg::*;
#(
    parameter int TAR_CYC = 3,
    parameter int TIMEOUT = 256,
    parameter int BUSY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_stb,
    input  logic              din,
    input  logic              req_go,
    input  logic [1:0]        req_id,
    input  logic              req_ipoll,
    input  logic              req_read,
    input  logic [1:0]        req_size,
    output logic              rsp_valid,
    output logic [2:0]        rsp_kind,
    output logic [RD_W-1:0]   rsp_data,
    output logic [1:0]        rsp_irq,
    output logic [2:0]        rsp_dma,
    output logic              rsp_crc_ok,
    output logic              rsp_id_mismatch,
    output logic              rsp_timeout,
    output logic [BUSY_W-1:0] busy_cnt
);
    localparam int CNT_W = $clog2(TIMEOUT > 2*RD_W ? TIMEOUT : 2*RD_W);
    localparam logic [CNT_W-1:0] TAR_LAST = CNT_W'(TAR_CYC - 1);
    localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT - 1);
    localparam logic [CNT_W-1:0] ID_LAST  = CNT_W'(1);
    localparam logic [CNT_W-1:0] IRQ_LAST = CNT_W'(1);
    localparam logic [CNT_W-1:0] DMA_LAST = CNT_W'(2);
    localparam logic [CNT_W-1:0] CRC_LAST = CNT_W'(3);

    dec_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] rd_last;
    logic [3:0]       crc_q, crc_nx;
    logic             crc_clr, crc_en;

    logic [1:0]       ctx_id;
    logic             ctx_ipoll, ctx_read;
    logic [1:0]       ctx_size;
    logic [1:0]       id_q;
    logic             code0_q;
    logic             short_poll;
    rsp_kind_e        kind_q;

    // Read length from the latched request size
    always_comb begin
        unique case (ctx_size)
            2'b00:   rd_last = CNT_W'(7);
            2'b01:   rd_last = CNT_W'(15);
            default: rd_last = CNT_W'(31);
        endcase
    end

    assign short_poll = ctx_ipoll && (id_q == ctx_id) && !din;

    rsp_bitcnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_d != state_q),
        .inc   (fall_stb),
        .cnt   (cnt)
    );

    assign crc_clr = (state_q == S_IDLE) && req_go;
    always_comb begin
        unique case (state_q)
            S_WAIT:                                         crc_en = fall_stb && din;
            S_ID, S_CODE, S_RDATA, S_IRQF, S_DMAF, S_CRC:   crc_en = fall_stb;
            default:                                        crc_en = 1'b0;
        endcase
    end

    rsp_crc4 #(.W(4), .POLY(4'h7)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (crc_clr),
        .en     (crc_en),
        .bit_i  (din),
        .crc_q  (crc_q),
        .crc_nx (crc_nx)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_go) state_d = S_TAR_IN;
            S_TAR_IN:  if (fall_stb && cnt == TAR_LAST) state_d = S_WAIT;
            S_WAIT: begin
                if (fall_stb) begin
                    if (din)                   state_d = S_ID;
                    else if (cnt == TMO_LAST)  state_d = S_IDLE;
                end
            end
            S_ID:      if (fall_stb && cnt == ID_LAST) state_d = S_CODE;
            S_CODE: begin
                if (fall_stb) begin
                    if (cnt == '0) begin
                        if (short_poll) state_d = S_IRQF;
                    end else if ({code0_q, din} == 2'b00 && ctx_read) begin
                        state_d = S_RDATA;
                    end else begin
                        state_d = S_CRC;
                    end
                end
            end
            S_RDATA:   if (fall_stb && cnt == rd_last)  state_d = S_CRC;
            S_IRQF:    if (fall_stb && cnt == IRQ_LAST) state_d = S_DMAF;
            S_DMAF:    if (fall_stb && cnt == DMA_LAST) state_d = S_CRC;
            S_CRC:     if (fall_stb && cnt == CRC_LAST) state_d = S_TAR_OUT;
            S_TAR_OUT: if (fall_stb && cnt == TAR_LAST) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and field registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid       <= 1'b0;
            rsp_timeout     <= 1'b0;
            kind_q          <= RSP_NONE;
            rsp_data        <= '0;
            rsp_irq         <= '0;
            rsp_dma         <= '0;
            rsp_crc_ok      <= 1'b0;
            rsp_id_mismatch <= 1'b0;
            busy_cnt        <= '0;
            ctx_id          <= '0;
            ctx_ipoll       <= 1'b0;
            ctx_read        <= 1'b0;
            ctx_size        <= '0;
            id_q            <= '0;
            code0_q         <= 1'b0;
        end else begin
            rsp_valid   <= 1'b0;
            rsp_timeout <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (req_go) begin
                        ctx_id    <= req_id;
                        ctx_ipoll <= req_ipoll;
                        ctx_read  <= req_read;
                        ctx_size  <= req_size;
                    end
                end
                S_WAIT: begin
                    if (fall_stb && din) begin
                        id_q     <= '0;
                        rsp_data <= '0;
                        rsp_irq  <= '0;
                        rsp_dma  <= '0;
                    end else if (fall_stb && cnt == TMO_LAST) begin
                        rsp_timeout <= 1'b1;
                        kind_q      <= RSP_NONE;
                    end
                end
                S_ID:   if (fall_stb) id_q <= {din, id_q[1]};
                S_CODE: begin
                    if (fall_stb) begin
                        if (cnt == '0) begin
                            code0_q <= din;
                            if (short_poll) kind_q <= RSP_IRQPOLL;
                        end else begin
                            unique case ({code0_q, din})
                                2'b00:   kind_q <= ctx_read ? RSP_ACK_DATA : RSP_ACK;
                                2'b01:   kind_q <= RSP_BUSY;
                                2'b10:   kind_q <= RSP_ERR_LO;
                                default: kind_q <= RSP_ERR_HI;
                            endcase
                        end
                    end
                end
                S_RDATA: if (fall_stb) rsp_data <= {rsp_data[RD_W-2:0], din};
                S_IRQF:  if (fall_stb) rsp_irq  <= {rsp_irq[0], din};
                S_DMAF:  if (fall_stb) rsp_dma  <= {rsp_dma[1:0], din};
                S_CRC: begin
                    if (fall_stb && cnt == CRC_LAST) begin
                        rsp_crc_ok      <= (crc_nx == 4'h0);
                        rsp_id_mismatch <= (id_q != ctx_id);
                    end
                end
                S_TAR_OUT: begin
                    if (fall_stb && cnt == TAR_LAST) begin
                        rsp_valid <= 1'b1;
                        if (!rsp_id_mismatch) begin
                            if (kind_q != RSP_BUSY)  busy_cnt <= '0;
                            else if (busy_cnt != '1) busy_cnt <= busy_cnt + BUSY_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign rsp_kind = kind_q;

    AST_TAR_CRC_ZERO:   assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TAR_IN) |-> (crc_q == 4'h0));                               // R2
    AST_TIMEOUT_SRC:    assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |-> ($past(state_q) == S_WAIT) && (state_q == S_IDLE));       // R3
    AST_NO_EVENT_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_timeout));                                             // R3
    AST_DONE_PULSE:     assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                                // R9
    AST_DONE_FROM_TAR:  assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(state_q) == S_TAR_OUT) && (state_q == S_IDLE));      // R9
    AST_BUSY_STEP:      assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && kind_q == RSP_BUSY && !rsp_id_mismatch && $past(busy_cnt) != '1)
        |-> busy_cnt == $past(busy_cnt) + BUSY_W'(1));                            // R10
    AST_BUSY_CLEAR:     assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && kind_q != RSP_BUSY && !rsp_id_mismatch) |-> busy_cnt == '0); // R10
    AST_STROBE_ONLY:    assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_stb && state_q != S_IDLE) |=> $stable(crc_q));                     // R11

endmodule

// File: tb/slv_resp_dec_bench.sv
module slv_resp_dec_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fall_stb = 1'b0, din = 1'b0, req_go = 1'b0;
    logic [1:0]  req_id = '0, req_size = '0;
    logic        req_ipoll = 1'b0, req_read = 1'b0;
    logic        rsp_valid, rsp_crc_ok, rsp_id_mismatch, rsp_timeout;
    logic [2:0]  rsp_kind, rsp_dma;
    logic [1:0]  rsp_irq;
    logic [31:0] rsp_data;
    logic [7:0]  busy_cnt;

    always #4 clk = ~clk;

    slv_resp_dec u_slv_resp_dec (
        .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb), .din(din), .req_go(req_go),
        .req_id(req_id), .req_ipoll(req_ipoll), .req_read(req_read), .req_size(req_size),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data), .rsp_irq(rsp_irq),
        .rsp_dma(rsp_dma), .rsp_crc_ok(rsp_crc_ok), .rsp_id_mismatch(rsp_id_mismatch),
        .rsp_timeout(rsp_timeout), .busy_cnt(busy_cnt)
    );

    int n_chk = 0, n_bad = 0, n_valid = 0, n_tmo = 0;
    bit finished = 1'b0;
    logic [2:0]  s_kind;
    logic [31:0] s_data;
    logic [1:0]  s_irq;
    logic [2:0]  s_dma;
    logic        s_crc, s_mis;
    logic [7:0]  s_busy;
    logic [3:0]  bc;
    int          exp_busy = 0;

    // Snapshot on done pulses, away from the active edge
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_valid++;
            s_kind = rsp_kind; s_data = rsp_data; s_irq = rsp_irq; s_dma = rsp_dma;
            s_crc = rsp_crc_ok; s_mis = rsp_id_mismatch; s_busy = busy_cnt;
        end
        if (rst_n && rsp_timeout) n_tmo++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] crc_step(input logic [3:0] c, input logic b);
        logic f;
        f = c[3] ^ b;
        return {c[2], c[1] ^ f, c[0] ^ f, f};
    endfunction

    // One serial bit; line shows the opposite value between strobes (R11)
    task automatic send_bit(input logic b);
        @(negedge clk); din = b; fall_stb = 1'b1;
        @(negedge clk); fall_stb = 1'b0; din = ~b;
    endtask

    task automatic send_c(input logic b);
        send_bit(b);
        bc = crc_step(bc, b);
    endtask

    task automatic issue(input logic [1:0] id, input logic ip, input logic rd, input logic [1:0] sz);
        @(negedge clk);
        req_id = id; req_ipoll = ip; req_read = rd; req_size = sz; req_go = 1'b1;
        @(negedge clk); req_go = 1'b0;
    endtask

    // {rqid[55:54], ipoll[53], read[52], size[51:50], rid[49:48], code[47:46],
    //  data[45:14], irq[13:12], dma[11:9], bad_crc[8], gap[7:0]}
    localparam int NV = 14;
    localparam logic [55:0] VEC [NV] = '{
        {2'd1,1'b0,1'b0,2'd0,2'd1,2'b00,32'h0,        2'd0,3'd0,1'b0,8'd0},
        {2'd2,1'b0,1'b1,2'd2,2'd2,2'b00,32'hA5C31E7F, 2'd0,3'd0,1'b0,8'd5},
        {2'd0,1'b0,1'b1,2'd0,2'd0,2'b00,32'hFFFFFF96, 2'd0,3'd0,1'b0,8'd1},
        {2'd3,1'b0,1'b1,2'd1,2'd3,2'b00,32'h1234BEEF, 2'd0,3'd0,1'b0,8'd2},
        {2'd1,1'b0,1'b0,2'd0,2'd1,2'b01,32'h0,        2'd0,3'd0,1'b0,8'd0},
        {2'd1,1'b0,1'b1,2'd2,2'd1,2'b01,32'h0,        2'd0,3'd0,1'b0,8'd3},
        {2'd1,1'b0,1'b0,2'd0,2'd2,2'b11,32'h0,        2'd0,3'd0,1'b0,8'd0},
        {2'd1,1'b0,1'b0,2'd0,2'd1,2'b01,32'h0,        2'd0,3'd0,1'b0,8'd0},
        {2'd1,1'b0,1'b0,2'd0,2'd1,2'b11,32'h0,        2'd0,3'd0,1'b0,8'd0},
        {2'd2,1'b1,1'b0,2'd0,2'd2,2'b00,32'h0,        2'd2,3'd5,1'b0,8'd4},
        {2'd2,1'b1,1'b0,2'd0,2'd2,2'b10,32'h0,        2'd3,3'd7,1'b0,8'd0},
        {2'd1,1'b1,1'b0,2'd0,2'd3,2'b01,32'h0,        2'd1,3'd6,1'b0,8'd0},
        {2'd0,1'b0,1'b0,2'd0,2'd0,2'b00,32'h0,        2'd0,3'd0,1'b1,8'd0},
        {2'd3,1'b0,1'b1,2'd0,2'd3,2'b00,32'h0000005A, 2'd0,3'd0,1'b0,8'd255}
    };

    task automatic run_vec(input logic [55:0] v);
        logic [1:0] rq, rid, code, sz, irq; logic ip, rd, bad, shrt;
        logic [31:0] data, mask, e_data; logic [2:0] dma, e_kind; logic [7:0] gap;
        int len, v0;
        rq = v[55:54]; ip = v[53]; rd = v[52]; sz = v[51:50]; rid = v[49:48];
        code = v[47:46]; data = v[45:14]; irq = v[13:12]; dma = v[11:9]; bad = v[8]; gap = v[7:0];
        len  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        mask = (len == 32) ? 32'hFFFFFFFF : ((32'h1 << len) - 1);
        shrt = ip && (rid == rq) && !code[1];
        v0 = n_valid;
        issue(rq, ip, rd, sz);
        for (int k = 0; k < 3; k++) send_bit(1'b1);           // R2 turnaround ones ignored
        for (int k = 0; k < int'(gap); k++) send_bit(1'b0);
        bc = 4'h0;
        send_c(1'b1);
        send_c(rid[0]); send_c(rid[1]);                       // R4 LSB first
        if (shrt) begin
            send_c(1'b0);
            send_c(irq[1]); send_c(irq[0]);
            send_c(dma[2]); send_c(dma[1]); send_c(dma[0]);
            e_kind = 3'd5;
        end else begin
            send_c(code[1]); send_c(code[0]);
            case (code)
                2'b00:   e_kind = rd ? 3'd4 : 3'd0;
                2'b01:   e_kind = 3'd1;
                2'b10:   e_kind = 3'd2;
                default: e_kind = 3'd3;
            endcase
            if (e_kind == 3'd4)
                for (int k = len - 1; k >= 0; k--) send_c(data[k]);
        end
        bc = bc ^ {3'b000, bad};
        for (int k = 3; k >= 0; k--) send_bit(bc[k]);
        for (int k = 0; k < 3; k++) send_bit(1'b1);           // R9 closing turnaround
        repeat (3) @(negedge clk);
        e_data = (e_kind == 3'd4) ? (data & mask) : 32'h0;
        if (rid == rq) exp_busy = (e_kind == 3'd1) ? exp_busy + 1 : 0;
        check("R9 one done pulse", n_valid - v0, 1);
        check("R5 R6 kind", {29'h0, s_kind}, {29'h0, e_kind});
        check("R7 R11 read data", s_data, e_data);
        check("R6 irq field", {30'h0, s_irq}, shrt ? {30'h0, irq} : 32'h0);
        check("R6 dma field", {29'h0, s_dma}, shrt ? {29'h0, dma} : 32'h0);
        check("R8 crc ok", {31'h0, s_crc}, {31'h0, !bad});
        check("R4 id mismatch", {31'h0, s_mis}, {31'h0, rid != rq});
        check("R10 busy count", {24'h0, s_busy}, exp_busy);
    endtask

    initial begin
        int t0, v0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 valid", {31'h0, rsp_valid}, 0);
        check("R1 timeout", {31'h0, rsp_timeout}, 0);
        check("R1 kind none", {29'h0, rsp_kind}, 7);
        check("R1 data", rsp_data, 0);
        check("R1 busy", {24'h0, busy_cnt}, 0);
        check("R1 flags", {27'h0, rsp_irq, rsp_crc_ok, rsp_id_mismatch, 1'b0}, 0);

        // R2 strobes without a request do nothing
        for (int k = 0; k < 40; k++) send_bit(1'b1);
        repeat (2) @(negedge clk);
        check("R2 no event without req_go", n_valid + n_tmo, 0);

        // R3 timeout after 256 zeros
        t0 = n_tmo; v0 = n_valid;
        issue(2'd1, 1'b0, 1'b0, 2'd0);
        for (int k = 0; k < 3; k++) send_bit(1'b0);
        for (int k = 0; k < 256; k++) send_bit(1'b0);
        repeat (3) @(negedge clk);
        check("R3 timeout pulse", n_tmo - t0, 1);
        check("R3 no done on timeout", n_valid - v0, 0);
        check("R3 kind none after timeout", {29'h0, rsp_kind}, 7);
        check("R10 busy unchanged by timeout", {24'h0, busy_cnt}, 0);

        // Table walk (last entry: start bit on the 256th sample, R3)
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);
        check("R3 no stray timeout", n_tmo - t0, 1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule